// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port on-chip memory of 32-bit words split into four byte lanes. Every input is sampled on the rising clock edge: address, write data, three chip selects, two address strobes, a burst-advance request and the write controls. A read presented at one edge loads the output register at the next edge. A burst of four reads therefore returns its first word after two edges and then one word on each following cycle.

An access starts through one of two strobes. The host-side strobe always starts a read and is honoured only while the first chip select is active. The controller-side strobe starts either a read or a write. After a start, the advance input steps the low two address bits through a four-word burst. The step order is set by a mode pin: linear (wrapping add) or interleaved (XOR with the step count). A write is self-timed and takes data from the same edge as its address. The global write control forces all four lanes. Otherwise a byte-write qualifier gates the per-lane enables.

The data bus is split for pad-level use: an input word, an output word and a drive enable for the tri-state pad buffer. The drive enable follows the output-enable pin combinationally. A sleep pin makes every new access be ignored. These pins are plain level controls: there is no valid/ready handshake, so no back-pressure exists.

Top module: `burst_sram`

## Requirements
- R1: While rst_n is low and after its release, `dq_oe` is 0 until a read has reached the output register.
- R2: A low `adsc_n` with all selects active (`ce1_n`=0, `ce2`=1, `ce3_n`=0) captures `addr`. If it reads, that word is on `dq_out`, with `dq_oe`=1, after the second rising edge.
- R3: A low `adsp_n` is ignored while `ce1_n` is 1. With `ce1_n` low it starts a read even when the write controls are active, so memory is not changed.
- R4: A start with any select inactive deselects the block: neither that start nor later advances perform an access until the next selected start.
- R5: With `gw_n`=1 and `bwe_n`=0, lane i (bits 8i+7:8i of `dq_in`) is written exactly when `bw_n[i]`=0. The other lanes keep their contents.
- R6: `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` hold.
- R7: An access with `gw_n`=1 and either `bwe_n`=1 or `bw_n`=4'b1111 is a read.
- R8: With neither strobe taking effect, `adv_n`=0 on a selected burst accesses the next burst address. The upper address bits are kept. The low two bits are (first+k) mod 4 when `burst_linear`=1 and first XOR k when it is 0, for step k=1,2,3, wrapping after 3. With `adv_n`=1, no access occurs and the burst position holds.
- R9: Back-to-back reads give one new output word per cycle (a 3-1-1-1 burst pattern at the bus).
- R10: `dq_oe` is 1 only while the output register holds read data and `oe_n`=0. A change of `oe_n` takes effect without a clock edge.
- R11: While `sleep`=1, strobes, advances and writes are ignored: no memory change and no new read output.
- R12: A taking-effect strobe on the same edge as `adv_n`=0 restarts the burst at `addr` rather than advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control and pipeline state |
| addr | input | AW (8) | Word address |
| adsp_n | input | 1 | Host-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select 1, active low; also gates adsp_n |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Ignore all new accesses while high |
| dq_in | input | 32 | Write data from the bus pads |
| dq_out | output | 32 | Read data to the bus pads |
| dq_oe | output | 1 | Pad drive enable for dq_out |

## Verification
The memory is first filled with address-dependent words, so that every misrouted address shows up as a wrong word. Directed sequences then cover:

- partial lane masks against the global write, which shows whether lanes are gated independently or all together;
- linear against interleaved bursts from an odd and from an even first address, which separates add from XOR and checks the wrap;
- strobes under each deselecting select, under sleep, and on the same edge as an advance, which shows precedence and ignore rules.

A seeded random run mixes all controls. A reference model of the memory predicts every output word and every drive-enable value cycle by cycle.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STEP_W-1:0] load_lsb,
  input  logic              adv,
  input  logic              linear,
  output logic [STEP_W-1:0] nxt_lsb
);
  logic [STEP_W-1:0] first_q;
  logic [STEP_W-1:0] cnt_q;
  logic [STEP_W-1:0] step_nxt;

  assign step_nxt = cnt_q + 1'b1;
  assign nxt_lsb  = linear ? (first_q + step_nxt) : (first_q ^ step_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      first_q <= load_lsb;
      cnt_q   <= '0;
    end else if (adv) begin
      cnt_q   <= step_nxt;
    end
  end

  // R12: a start always rewinds the step count
  a_r12_load_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));
  // R8: an advance moves one step, wrapping
  a_r8_adv_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (cnt_q == STEP_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int WW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] lane_we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WW-1:0]    rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_vld,
  input  logic [WW-1:0] ld_data,
  input  logic          oe_n,
  output logic [WW-1:0] dq_out,
  output logic          dq_oe
);
  logic q_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      dq_out <= '0;
    end else begin
      q_vld <= ld_vld;
      if (ld_vld) dq_out <= ld_data;
    end
  end

  assign dq_oe = q_vld & ~oe_n;

  // R9: output data exists only one edge after a pending read
  a_r9_out_follows_pend: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |-> $past(ld_vld));
  // R10: pad is never driven while output enable is high
  a_r10_oe_gates_pad: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int WW    = LANES * LANE_W,
  localparam int BW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             burst_linear,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [WW-1:0]    dq_in,
  output logic [WW-1:0]    dq_out,
  output logic             dq_oe
);
  import burst_sram_pkg::*;

  logic             ce_ok, host_start, ctrl_start, start, cont;
  logic             sel_q;
  logic [AW-BW-1:0] base_q;
  logic [BW-1:0]    nxt_lsb;
  logic [AW-1:0]    eff_addr;
  logic [LANES-1:0] lane_mask, lane_we;
  acc_kind_e        kind;
  logic             rd_pend_q;
  logic [AW-1:0]    rd_addr_q;
  logic [WW-1:0]    arr_rd;

  assign ce_ok      = ~ce1_n & ce2 & ~ce3_n;
  assign host_start = ~adsp_n & ~ce1_n;
  assign ctrl_start = ~adsc_n;
  assign start      = ~sleep & (host_start | ctrl_start);
  assign cont       = ~sleep & ~host_start & ~ctrl_start & ~adv_n & sel_q;
  assign eff_addr   = start ? addr : {base_q, nxt_lsb};
  assign lane_mask  = ~gw_n ? {LANES{1'b1}} : (~bwe_n ? ~bw_n : '0);

  always_comb begin
    kind = ACC_IDLE;
    if ((start && ce_ok) || cont) begin
      if (!(start && host_start) && (|lane_mask)) kind = ACC_WRITE;
      else                                        kind = ACC_READ;
    end
  end

  assign lane_we = (kind == ACC_WRITE) ? lane_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      base_q    <= '0;
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (start) begin
        sel_q  <= ce_ok;
        base_q <= addr[AW-1:BW];
      end
      rd_pend_q <= (kind == ACC_READ);
      rd_addr_q <= eff_addr;
    end
  end

  burst_addr_ctr #(.STEP_W(BW)) i_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_lsb (addr[BW-1:0]),
    .adv      (cont),
    .linear   (burst_linear),
    .nxt_lsb  (nxt_lsb)
  );

  sram_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .wr_addr (eff_addr),
    .wr_data (dq_in),
    .rd_addr (rd_addr_q),
    .rd_data (arr_rd)
  );

  sram_out_stage #(.WW(WW)) i_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_vld  (rd_pend_q),
    .ld_data (arr_rd),
    .oe_n    (oe_n),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

  // R11: sleep blocks every new read
  a_r11_sleep_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rd_pend_q);
  // R11: sleep blocks every write
  a_r11_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0));
  // R4: a deselecting start yields no read
  a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adsc_n && !(~ce1_n & ce2 & ~ce3_n)) |=> !rd_pend_q);
  // R3: a host strobe with all selects active reads
  a_r3_host_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adsp_n && !ce1_n && ce2 && !ce3_n) |=> rd_pend_q);
  // R3: a host strobe never writes
  a_r3_host_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n) |-> (lane_we == '0));
endmodule

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n;
  logic [3:0]    bw_n;
  logic          burst_linear, oe_n, sleep;
  logic [31:0]   dq_in, dq_out;
  logic          dq_oe;

  int total = 0;
  int bad   = 0;
  string cur_tag = "R2";

  // reference model state
  logic [31:0]   m_mem [DEPTH];
  logic          m_sel = 1'b0;
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_first = '0, m_cnt = '0;
  logic          m_pend = 1'b0;
  logic [AW-1:0] m_paddr = '0;
  logic          exp_vld = 1'b0;
  logic [31:0]   exp_q = '0;

  always #4 clk = ~clk;

  burst_sram #(.DEPTH(DEPTH)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .burst_linear(burst_linear), .oe_n(oe_n),
    .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F00;
  endfunction

  function automatic logic [1:0] blsb(input logic [1:0] f, input logic [1:0] k,
                                      input logic lin);
    return lin ? f + k : f ^ k;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    addr = '0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    ce1_n = 0; ce2 = 1; ce3_n = 0; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    oe_n = 0; sleep = 0; dq_in = '0;
  endtask

  // predict state after the coming edge from the present inputs
  task automatic model_step();
    logic ce_ok, ps, cs, st, ct, acc, wr;
    logic [AW-1:0] ea;
    logic [3:0] we;
    exp_vld = m_pend;
    if (m_pend) exp_q = m_mem[m_paddr];
    ce_ok = !ce1_n && ce2 && !ce3_n;
    ps = !adsp_n && !ce1_n;
    cs = !adsc_n;
    st = !sleep && (ps || cs);
    ct = !sleep && !ps && !cs && !adv_n && m_sel;
    acc = (st && ce_ok) || ct;
    ea = st ? addr : {m_base, blsb(m_first, m_cnt + 2'd1, burst_linear)};
    we = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
    wr = acc && !(st && ps) && (we != 0);
    if (wr)
      for (int l = 0; l < 4; l++)
        if (we[l]) m_mem[ea][l*8 +: 8] = dq_in[l*8 +: 8];
    m_pend = acc && !wr;
    m_paddr = ea;
    if (st) begin
      m_sel = ce_ok; m_base = addr[AW-1:2]; m_first = addr[1:0]; m_cnt = 0;
    end else if (ct) m_cnt = m_cnt + 2'd1;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #2;
    chk(dq_oe == (exp_vld && !oe_n), {cur_tag, " oe"}, 32'(dq_oe),
        32'(exp_vld && !oe_n));
    if (exp_vld) chk(dq_out == exp_q, {cur_tag, " data"}, dq_out, exp_q);
    idle();
  endtask

  task automatic wr_c(input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] bwn, input logic g);
    addr = a; adsc_n = 0; dq_in = d; bw_n = bwn; bwe_n = g; gw_n = !g;
    if (!g) bwe_n = 0;
    cyc();
  endtask

  task automatic rd_burst(input logic [AW-1:0] a, input logic host, input int n);
    addr = a; burst_linear = burst_linear;
    if (host) adsp_n = 0; else adsc_n = 0;
    cyc();
    for (int k = 0; k < n; k++) begin adv_n = 0; cyc(); end
    cyc(); cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    idle(); burst_linear = 1; rst_n = 0;
    repeat (3) @(posedge clk);
    #2 chk(dq_oe == 0, "R1 reset", 32'(dq_oe), 0);
    rst_n = 1;
    @(posedge clk); #2 chk(dq_oe == 0, "R1 after reset", 32'(dq_oe), 0);

    cur_tag = "R6";
    for (int i = 0; i < DEPTH; i++) wr_c(AW'(i), pat(i), 4'hF, 1'b1);

    cur_tag = "R2"; rd_burst(8'd10, 0, 0);

    cur_tag = "R5";
    wr_c(8'd5, 32'h1122_3344, 4'b1010, 1'b0);
    addr = 8'd5; adsc_n = 0; cyc(); cyc();
    chk(dq_out == {pat(5)[31:24], 8'h22, pat(5)[15:8], 8'h44}, "R5 lanes",
        dq_out, {pat(5)[31:24], 8'h22, pat(5)[15:8], 8'h44});
    cyc();

    cur_tag = "R6";
    addr = 8'd6; adsc_n = 0; gw_n = 0; bwe_n = 1; bw_n = 4'hF; dq_in = 32'hDEAD_BEEF; cyc();
    rd_burst(8'd6, 0, 0);

    cur_tag = "R7";
    addr = 8'd7; adsc_n = 0; bwe_n = 0; bw_n = 4'hF; dq_in = 32'h0; cyc(); cyc();
    chk(dq_out == pat(7), "R7 no write", dq_out, pat(7));
    addr = 8'd7; adsc_n = 0; bwe_n = 1; bw_n = 4'h0; cyc(); cyc();
    chk(dq_oe == 1 && dq_out == pat(7), "R7 bwe high", dq_out, pat(7));

    cur_tag = "R3";
    addr = 8'd12; adsp_n = 0; ce1_n = 1; cyc(); cyc();
    chk(dq_oe == 0, "R3 ignored", 32'(dq_oe), 0);
    addr = 8'd12; adsp_n = 0; gw_n = 0; dq_in = 32'h0; cyc(); cyc();
    chk(dq_out == pat(12), "R3 host read", dq_out, pat(12));
    cyc();

    cur_tag = "R4";
    addr = 8'd20; adsc_n = 0; ce2 = 0; cyc();
    adv_n = 0; cyc(); adv_n = 0; cyc();
    chk(dq_oe == 0, "R4 deselect", 32'(dq_oe), 0);
    addr = 8'd20; adsc_n = 0; ce3_n = 1; gw_n = 0; dq_in = 32'h0; cyc(); cyc();
    rd_burst(8'd20, 0, 0);

    cur_tag = "R8"; burst_linear = 1; rd_burst(8'd34, 0, 3);
    burst_linear = 0; rd_burst(8'd39, 1, 3);
    rd_burst(8'd40, 1, 5);
    addr = 8'd45; adsc_n = 0; cyc(); adv_n = 0; cyc(); cyc(); cyc();
    chk(dq_oe == 0, "R8 pause", 32'(dq_oe), 0);
    adv_n = 0; cyc(); cyc(); cyc();

    cur_tag = "R9"; burst_linear = 1;
    addr = 8'd50; adsc_n = 0; cyc(); adv_n = 0; cyc();
    chk(dq_oe == 1 && dq_out == pat(50), "R9 first", dq_out, pat(50));
    adv_n = 0; cyc();
    chk(dq_out == pat(51), "R9 second", dq_out, pat(51));
    cyc(); cyc();

    cur_tag = "R12";
    addr = 8'd60; adsc_n = 0; cyc(); adv_n = 0; cyc();
    addr = 8'd70; adsc_n = 0; adv_n = 0; cyc(); cyc();
    chk(dq_out == pat(70), "R12 restart", dq_out, pat(70));
    cyc();

    cur_tag = "R11";
    addr = 8'd80; adsc_n = 0; gw_n = 0; sleep = 1; dq_in = 32'h0; cyc();
    addr = 8'd80; adsc_n = 0; sleep = 1; cyc(); cyc();
    chk(dq_oe == 0, "R11 no read", 32'(dq_oe), 0);
    rd_burst(8'd80, 0, 0);

    cur_tag = "R10";
    addr = 8'd90; adsc_n = 0; cyc(); oe_n = 1; model_step();
    @(posedge clk); #2;
    chk(dq_oe == 0, "R10 oe high", 32'(dq_oe), 0);
    #1 oe_n = 0; #1;
    chk(dq_oe == 1 && dq_out == pat(90), "R10 async", dq_out, pat(90));
    idle(); cyc();

    cur_tag = "R9 random";
    for (int n = 0; n < 3000; n++) begin
      addr   = AW'($urandom);
      adsp_n = ($urandom % 5) != 0;
      adsc_n = ($urandom % 4) != 0;
      adv_n  = ($urandom % 3) == 0;
      ce1_n  = ($urandom % 8) == 0;
      ce2    = ($urandom % 8) != 0;
      ce3_n  = ($urandom % 8) == 0;
      gw_n   = ($urandom % 6) != 0;
      bwe_n  = ($urandom % 2) != 0;
      bw_n   = 4'($urandom);
      burst_linear = 1'($urandom);
      oe_n   = ($urandom % 6) == 0;
      sleep  = ($urandom % 12) == 0;
      dq_in  = $urandom;
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule